// File: doc/BRIEF.md
# Buffered Serial Mode-Control Register

This block holds the eight mode-control bits of a frequency synthesizer. Software or a controller loads them over a three-wire port made of a serial clock, a serial data line and a write strobe. Each rising serial clock moves one data bit into a shift register. When the write strobe falls, the shifted word is copied into a holding buffer. Only the holding buffer drives the synthesizer, so the active controls stay steady while a new word is still arriving.

An active-low enable line sits between the buffer and every output. While the line is high, all functions are off. This keeps the synthesizer safe until a known word has been written. The buffered bits drive three things:
- a power-down level;
- a continuous counter-load level;
- a source selector for the serial data output.

The data output can show one of these sources:
- the main-divider pulse;
- the reference-divider pulse;
- the prescaler modulus-select line;
- a bit-serial view of a parallel auxiliary word. This word is sent least significant bit first and advances on the same serial clock.

The three serial inputs are oversampled and synchronised into the block's system clock. Everything inside therefore runs in one clock domain.

Top module: `synth_mode_ctl`

## Requirements
- R1: Serial data is taken on each rising edge of `ser_clk`, most significant bit first. After eight edges, bit 7 holds the first bit received and bit 0 holds the last.
- R2: The holding buffer changes only on a falling edge of `ser_wstb`. Shifting new bits without that falling edge leaves every output as it was.
- R3: While `func_en_n` is high, `pwr_down`, `cnt_load`, `dout` and `sel_conflict` are all low, whatever the buffer holds.
- R4: With `func_en_n` low, buffer bit 3 drives `pwr_down` and buffer bit 4 drives `cnt_load`.
- R5: With `func_en_n` low, `dout` follows the selected live input:
  - bit 2 set: `div_main`;
  - bit 5 set: `msel_in`;
  - bit 6 set: `div_ref`;
  - none of bits 1, 2, 5 and 6 set: `dout` is low.
- R6: When bit 1 becomes active, `aux_word` is captured and its bit 0 appears on `dout`.
  - Each later rising `ser_clk` moves the output to the next higher bit.
  - After all `AUX_W` bits have been sent, `dout` stays low.
  - The next time bit 1 becomes active, a new `aux_word` is captured.
- R7: When more than one of bits 1, 2, 5 and 6 is active:
  - the source is chosen by priority in the order 1, 2, 5, 6;
  - `sel_conflict` goes high.
- R8: Bits 0 and 7 are reserved and have no effect on any output.
- R9: The serial port keeps loading and capturing words while `pwr_down` is asserted.
- R10: After a synchronous reset (`rst_n` low), the shift register and the buffer are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial port clock; bits are taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_wstb | input | 1 | Write strobe; its falling edge copies the shifted word into the buffer |
| func_en_n | input | 1 | Active-low gate for all buffered functions |
| aux_word | input | AUX_W | Parallel word sent out bit-serially when bit 1 is active |
| div_main | input | 1 | Main-divider pulse |
| div_ref | input | 1 | Reference-divider pulse |
| msel_in | input | 1 | Prescaler modulus-select line |
| dout | output | 1 | Serial data output carrying the selected source |
| pwr_down | output | 1 | Power-down command |
| cnt_load | output | 1 | Continuous counter-load command |
| sel_conflict | output | 1 | High when more than one output source is requested |

## Verification
A single rising `ser_clk` edge can do two jobs in the same system-clock cycle: it shifts a bit into the command register, and it advances the auxiliary shift-out on `dout`. The bench provokes this by selecting the auxiliary source and then clocking further command words in without a strobe. It compares `dout` after every serial edge with a model of the auxiliary word, which runs on to zeros once the word is exhausted. It then strobes and checks that the buffer holds exactly the word shifted during that read-out.

// File: rtl/smc_pkg.sv
// Package: shared widths, bit positions and source codes of the mode-control register.
// Assumes: an 8-bit control word, with bit positions fixed by the function each bit enables.
package smc_pkg;
    localparam int CTRL_W   = 8;
    localparam int BIT_AUX  = 1;
    localparam int BIT_MAIN = 2;
    localparam int BIT_PD   = 3;
    localparam int BIT_LOAD = 4;
    localparam int BIT_MSEL = 5;
    localparam int BIT_REF  = 6;

    typedef logic [CTRL_W-1:0] ctrl_t;

    // Bits that carry a function; the reserved positions are cleared by this mask.
    localparam ctrl_t FUNC_MASK = ctrl_t'((1 << BIT_AUX) | (1 << BIT_MAIN) | (1 << BIT_PD) |
                                          (1 << BIT_LOAD) | (1 << BIT_MSEL) | (1 << BIT_REF));

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_AUX,
        SRC_MAIN,
        SRC_MSEL,
        SRC_REF
    } src_t;
endpackage

// File: rtl/smc_serial_port.sv
// Module: smc_serial_port
// Synchronises the three serial inputs into clk and shifts data in MSB first on
// each rising serial clock. Copies the shifted word into the holding buffer on a
// falling write strobe.
// Assumes: serial inputs are slow next to clk (each level held >= SYNC_STAGES+1 cycles),
// and data is stable around each rising serial clock.
module smc_serial_port
    import smc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ser_clk,
    input  logic  ser_dat,
    input  logic  ser_wstb,
    output ctrl_t ctrl_q,
    output logic  ser_rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] pipe [SYNC_STAGES];
    logic       clk_prev;
    logic       stb_prev;
    logic       wstb_fall;
    ctrl_t      shift_q;

    // Purpose: synchronizer chain for {clock, data, strobe}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= {ser_wstb, ser_dat, ser_clk};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    // Purpose: remember the last synchronised clock and strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            stb_prev <= 1'b0;
        end else begin
            clk_prev <= pipe[LAST][0];
            stb_prev <= pipe[LAST][2];
        end
    end

    assign ser_rise  = pipe[LAST][0] & ~clk_prev;
    assign wstb_fall = ~pipe[LAST][2] & stb_prev;

    // Purpose: MSB-first shift register, one bit per serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (ser_rise) shift_q <= {shift_q[CTRL_W-2:0], pipe[LAST][1]};
    end

    // Purpose: holding buffer, copied from the shift register on a strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (wstb_fall) ctrl_q <= shift_q;
    end
endmodule

// File: rtl/smc_aux_serializer.sv
// Module: smc_aux_serializer
// Captures a parallel word when its source becomes selected and presents it LSB first,
// advancing one bit per serial clock rise. Gives zeros once AUX_W bits have gone out.
// Assumes: sel is a level in the clk domain; ser_rise is a one-cycle pulse.
module smc_aux_serializer #(
    parameter int AUX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             ser_rise,
    input  logic [AUX_W-1:0] aux_word,
    output logic             aux_bit
);
    localparam int CNT_W = $clog2(AUX_W + 1);

    logic [AUX_W-1:0] sr_q;
    logic [CNT_W-1:0] left_q;
    logic             sel_q;

    // Purpose: capture on selection, shift per serial clock, clear when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            left_q <= '0;
            sel_q  <= 1'b0;
        end else begin
            sel_q <= sel;
            if (!sel) begin
                left_q <= '0;
            end else if (!sel_q) begin
                sr_q   <= aux_word;
                left_q <= CNT_W'(AUX_W);
            end else if (ser_rise && left_q != '0) begin
                sr_q   <= sr_q >> 1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign aux_bit = (left_q != '0) & sr_q[0];
endmodule

// File: rtl/smc_out_select.sv
// Module: smc_out_select
// Chooses the data output source from the four routing bits by fixed priority
// (aux, main, modulus select, reference) and flags requests for more than one source.
// Assumes: route bits are already gated by the enable line.
module smc_out_select
    import smc_pkg::*;
(
    input  logic [3:0] route,
    input  logic       aux_bit,
    input  logic       div_main,
    input  logic       msel_in,
    input  logic       div_ref,
    output logic       dout,
    output logic       conflict
);
    src_t       src;
    logic [2:0] n_req;

    // Purpose: priority decode of the requested source.
    always_comb begin
        if      (route[0]) src = SRC_AUX;
        else if (route[1]) src = SRC_MAIN;
        else if (route[2]) src = SRC_MSEL;
        else if (route[3]) src = SRC_REF;
        else               src = SRC_NONE;
    end

    // Purpose: drive the chosen source onto the data output.
    always_comb begin
        unique case (src)
            SRC_AUX:  dout = aux_bit;
            SRC_MAIN: dout = div_main;
            SRC_MSEL: dout = msel_in;
            SRC_REF:  dout = div_ref;
            default:  dout = 1'b0;
        endcase
    end

    // Purpose: count requests to detect an over-subscribed selection.
    always_comb begin
        n_req = '0;
        for (int i = 0; i < 4; i++) n_req = n_req + {2'b00, route[i]};
        conflict = (n_req > 3'd1);
    end
endmodule

// File: rtl/synth_mode_ctl.sv
// Module: synth_mode_ctl (top)
// Buffered serial mode-control register: serial port, enable gating, control levels
// and data-output routing.
// Assumes: func_en_n is held high from power-up until a known word has been strobed in.
module synth_mode_ctl
    import smc_pkg::*;
#(
    parameter int AUX_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_wstb,
    input  logic             func_en_n,
    input  logic [AUX_W-1:0] aux_word,
    input  logic             div_main,
    input  logic             div_ref,
    input  logic             msel_in,
    output logic             dout,
    output logic             pwr_down,
    output logic             cnt_load,
    output logic             sel_conflict
);
    ctrl_t      ctrl_q;
    ctrl_t      act;
    logic       ser_rise;
    logic       aux_bit;
    logic [3:0] route;

    smc_serial_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .ser_wstb (ser_wstb),
        .ctrl_q   (ctrl_q),
        .ser_rise (ser_rise)
    );

    // Purpose: enable gating and removal of reserved bits.
    assign act = func_en_n ? '0 : (ctrl_q & FUNC_MASK);

    assign pwr_down = act[BIT_PD];
    assign cnt_load = act[BIT_LOAD];
    assign route    = {act[BIT_REF], act[BIT_MSEL], act[BIT_MAIN], act[BIT_AUX]};

    smc_aux_serializer #(.AUX_W(AUX_W)) u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (act[BIT_AUX]),
        .ser_rise (ser_rise),
        .aux_word (aux_word),
        .aux_bit  (aux_bit)
    );

    smc_out_select u_sel (
        .route    (route),
        .aux_bit  (aux_bit),
        .div_main (div_main),
        .msel_in  (msel_in),
        .div_ref  (div_ref),
        .dout     (dout),
        .conflict (sel_conflict)
    );
endmodule

// File: rtl/smc_checker.sv
// Module: smc_checker
// Property checks for synth_mode_ctl, bound to every instance of it.
// Assumes: SYNC_STAGES small (the strobe quiet counter saturates at 15).
module smc_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ser_wstb,
    input logic       func_en_n,
    input logic       div_main,
    input logic       dout,
    input logic       pwr_down,
    input logic       cnt_load,
    input logic       sel_conflict,
    input logic [7:0] ctrl_q
);
    localparam logic [3:0] QUIET_LIM = 4'(SYNC_STAGES + 2);

    logic [3:0] quiet;

    // Purpose: count cycles since the raw strobe was last seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)            quiet <= 4'hF;
        else if (ser_wstb)     quiet <= '0;
        else if (quiet != 4'hF) quiet <= quiet + 1'b1;
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet > QUIET_LIM) |=> $stable(ctrl_q)); // R2
    AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        func_en_n |-> !(pwr_down || cnt_load || dout || sel_conflict)); // R3
    AST_PD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!func_en_n && ctrl_q[3]) |-> pwr_down); // R4
    AST_MAIN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!func_en_n && ctrl_q[2] && !ctrl_q[1]) |-> (dout == div_main)); // R5
    AST_CONFLICT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sel_conflict |-> !func_en_n); // R7
endmodule

bind synth_mode_ctl smc_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_wstb     (ser_wstb),
    .func_en_n    (func_en_n),
    .div_main     (div_main),
    .dout         (dout),
    .pwr_down     (pwr_down),
    .cnt_load     (cnt_load),
    .sel_conflict (sel_conflict),
    .ctrl_q       (ctrl_q)
);

// File: tb/synth_mode_ctl_bench.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random words, checked against a bench-side model.
module synth_mode_ctl_bench;
    localparam int AUX_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_wstb = 1'b0, func_en_n = 1'b1;
    logic [AUX_W-1:0] aux_word = '0;
    logic div_main = 1'b0, div_ref = 1'b0, msel_in = 1'b0;
    logic dout, pwr_down, cnt_load, sel_conflict;

    int tests = 0;
    int fails = 0;

    // Bench-side model state
    logic [7:0]       m_sh = '0, m_bf = '0;
    logic [AUX_W-1:0] m_sr = '0;
    int               m_cnt = 0;
    logic             m_prev = 1'b0;

    always #2.5 clk = ~clk;

    synth_mode_ctl #(.AUX_W(AUX_W), .SYNC_STAGES(2)) u_synth_mode_ctl (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_wstb(ser_wstb), .func_en_n(func_en_n), .aux_word(aux_word),
        .div_main(div_main), .div_ref(div_ref), .msel_in(msel_in),
        .dout(dout), .pwr_down(pwr_down), .cnt_load(cnt_load),
        .sel_conflict(sel_conflict)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] act_bits();
        return func_en_n ? 8'h00 : (m_bf & 8'h7E);
    endfunction

    function automatic logic exp_dout();
        logic [7:0] a = act_bits();
        if (a[1]) return (m_cnt != 0) && m_sr[0];
        if (a[2]) return div_main;
        if (a[5]) return msel_in;
        if (a[6]) return div_ref;
        return 1'b0;
    endfunction

    function automatic logic exp_conf();
        logic [7:0] a = act_bits();
        return (int'(a[1]) + int'(a[2]) + int'(a[5]) + int'(a[6])) > 1;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_settle();
        logic a1 = !func_en_n && m_bf[1];
        if (!a1) m_cnt = 0;
        else if (!m_prev) begin m_sr = aux_word; m_cnt = AUX_W; end
        m_prev = a1;
    endtask

    task automatic ser_bit(input logic b);
        @(negedge clk); ser_dat = b;
        wait_n(3); ser_clk = 1'b1;
        wait_n(5); ser_clk = 1'b0;
        wait_n(3);
        m_sh = {m_sh[6:0], b};
        if (m_prev && m_cnt != 0) begin m_sr = m_sr >> 1; m_cnt--; end
    endtask

    task automatic send(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) ser_bit(w[i]);
    endtask

    task automatic strobe();
        @(negedge clk); ser_wstb = 1'b1;
        wait_n(4); ser_wstb = 1'b0;
        wait_n(5);
        m_bf = m_sh;
        model_settle();
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); func_en_n = v;
        wait_n(4);
        model_settle();
    endtask

    task automatic check_outs(input string req);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            div_main = 1'($urandom); div_ref = 1'($urandom); msel_in = 1'($urandom);
            #1;
            check({req, " dout"}, 8'(dout), 8'(exp_dout()));
        end
        check({req, " pwr_down"}, 8'(pwr_down), 8'(act_bits()[3]));
        check({req, " cnt_load"}, 8'(cnt_load), 8'(act_bits()[4]));
        check({req, " sel_conflict"}, 8'(sel_conflict), 8'(exp_conf()));
    endtask

    task automatic load(input logic [7:0] w);
        send(w);
        strobe();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_n(6);
        rst_n = 1'b1;
        wait_n(2);
        // R10: reset state
        check("R10 dout", 8'(dout), 8'h0);
        check("R10 pwr_down", 8'(pwr_down), 8'h0);
        check("R10 cnt_load", 8'(cnt_load), 8'h0);
        check("R10 sel_conflict", 8'(sel_conflict), 8'h0);
        set_en(1'b0);
        check_outs("R10 empty buffer enabled");
        set_en(1'b1);

        // R3: everything requested, enable high
        aux_word = 12'hA5C;
        load(8'h7E);
        check_outs("R3 disabled");
        // R4 + R7: enable low turns all on, aux wins priority
        set_en(1'b0);
        check_outs("R4 R7 all on");

        // R8: reserved bits only
        load(8'h81);
        check_outs("R8 reserved");

        // R1: bit 3 vs its mirror bit 4
        load(8'h08);
        check_outs("R1 msb first");
        check("R1 pd set", 8'(pwr_down), 8'h1);
        check("R1 load clear", 8'(cnt_load), 8'h0);

        // R2: shift without strobe leaves outputs alone
        send(8'h14);
        check_outs("R2 no strobe");
        check("R2 pd held", 8'(pwr_down), 8'h1);
        strobe();
        check_outs("R2 after strobe");

        // R9: port keeps working under power down
        load(8'h18);
        check_outs("R9 pd on");
        load(8'h04);
        check_outs("R9 reload under pd");
        check("R9 pd released", 8'(pwr_down), 8'h0);

        // R5: each single source and none
        load(8'h20); check_outs("R5 msel");
        load(8'h40); check_outs("R5 ref");
        load(8'h00); check_outs("R5 none");

        // R7: conflicts and priority
        load(8'h24); check_outs("R7 main over msel");
        load(8'h60); check_outs("R7 msel over ref");
        load(8'h42); check_outs("R7 aux over ref");

        // R6: aux shift-out while new words keep arriving (same serial edges)
        load(8'h00);
        aux_word = 12'h9B3;
        load(8'h02);
        check("R6 first bit", 8'(dout), 8'(aux_word[0]));
        for (int i = 0; i < AUX_W + 3; i++) begin
            ser_bit(1'($urandom));
            @(negedge clk); #1;
            check("R6 shift-out", 8'(dout), 8'(exp_dout()));
        end
        check("R6 zero after word", 8'(dout), 8'h0);
        strobe();
        check("R6 R2 word shifted during read-out", 8'(pwr_down), 8'(act_bits()[3]));
        check_outs("R6 after strobe");
        load(8'h00);
        aux_word = 12'h5E1;
        load(8'h02);
        check("R6 reload", 8'(dout), 8'(aux_word[0]));
        ser_bit(1'b0);
        check("R6 reload bit1", 8'(dout), 8'(aux_word[1]));

        // Random words, enable toggles, occasional un-strobed shifts
        for (int n = 0; n < 40; n++) begin
            logic [7:0] w = 8'($urandom);
            if ($urandom_range(0, 3) == 0) set_en(~func_en_n);
            aux_word = AUX_W'($urandom);
            send(w);
            if ($urandom_range(0, 4) == 0) begin
                check_outs("R2 random no strobe");
            end else begin
                strobe();
                check_outs("R4 R5 R7 random");
                if (act_bits()[1]) begin
                    ser_bit(1'($urandom));
                    @(negedge clk); #1;
                    check("R6 random shift", 8'(dout), 8'(exp_dout()));
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule